// File: doc/BRIEF.md
# Queued Lock Arbiter for a Home-Node Directory

This block sits at the home node of a distributed shared-memory system and arbitrates a set of hardware locks among a small group of nodes. Waiting nodes do not spin on a shared variable. The block keeps a small directory record for each lock: a busy flag, the current owner and the last waiter. Each node also has a successor link for each lock. Together these form a first-in first-out chain of the nodes waiting for that lock.

Each cycle the block accepts at most one request. A request carries a node number, a lock number and an operation: take or give back. A take on a free lock is answered at once with a grant. A take on an owned lock adds the node to the end of that lock's chain and gives no reply. When the owner gives the lock back, exactly one grant goes out, to the oldest waiter, and every other waiter stays untouched. Malformed traffic gets a one-cycle error pulse that carries a reason code, and it leaves the lock state unchanged.

Top module: `lkq_lock_mgr`

## Requirements
- R1: After synchronous reset, gnt_valid and err_valid are low and every lock is free.
- R2: A take (req_op=0) on a free lock raises gnt_valid on the next cycle, with gnt_node and gnt_lock equal to the request's node and lock. That node becomes the owner.
- R3: A take on an owned lock from a node not yet in that lock's chain appends the node to the chain. On the next cycle gnt_valid and err_valid both stay low.
- R4: A give-back (req_op=1) by the owner while waiters exist produces one grant on the next cycle, naming the oldest waiter and the same lock. That waiter becomes the owner.
- R5: Waiters on one lock are granted strictly in the order in which their takes were accepted.
- R6: A give-back by the owner with no waiters makes the lock free and clears its last-waiter record, and produces no grant. A later take on that lock is granted at once.
- R7: A give-back from a node that is not the owner, or on a free lock, raises err_valid with err_kind=1 on the next cycle. The owner and the chain stay unchanged.
- R8: A take from a node that already owns or waits for the same lock raises err_valid with err_kind=0 on the next cycle. The node is not enqueued a second time.
- R9: Locks are independent. A request on one lock never changes the owner or the chain of another lock.
- R10: In a cycle with req_valid low, the next cycle has gnt_valid and err_valid low. Each request produces at most one of grant and error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 1 | 0 = take lock, 1 = give lock back |
| req_node | input | NID_W | Requesting node |
| req_lock | input | LID_W | Lock addressed |
| gnt_valid | output | 1 | Registered grant pulse |
| gnt_node | output | NID_W | Node receiving the lock |
| gnt_lock | output | LID_W | Lock granted |
| err_valid | output | 1 | Registered error pulse |
| err_kind | output | 1 | 0 = duplicate take, 1 = give-back by non-owner |

## Verification
The assertions check single-cycle outcomes on every cycle:
- a take on a free lock is granted to the requester on the next cycle;
- a take on an owned lock stays silent;
- duplicate takes and foreign give-backs map to the right error code;
- an idle cycle produces nothing;
- a node is never linked into a chain it already belongs to.

Only the bench's scenarios can show the multi-request properties. These are first-come first-served ordering through long chains, that a rejected request leaves the chain intact, that a lock is reusable after it drains, and that locks are isolated. The bench shows these by comparing every response with a queue model over directed sequences and a long pseudo-random sweep across all nodes and locks.

// File: rtl/lkq_pkg.sv
package lkq_pkg;

  typedef enum logic {
    OP_TAKE = 1'b0,
    OP_GIVE = 1'b1
  } lk_op_e;

  typedef enum logic {
    ERR_DUP_TAKE = 1'b0,
    ERR_NOT_OWNER = 1'b1
  } lk_err_e;

endpackage

// File: rtl/lkq_dir_table.sv
module lkq_dir_table #(
  parameter int NUM_NODES = 4,
  parameter int NUM_LOCKS = 8,
  localparam int NID_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int LID_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LID_W-1:0] rd_lock,
  output logic             rd_busy,
  output logic [NID_W-1:0] rd_owner,
  output logic [NID_W-1:0] rd_last,
  input  logic             wr_en,
  input  logic [LID_W-1:0] wr_lock,
  input  logic             wr_busy,
  input  logic [NID_W-1:0] wr_owner,
  input  logic [NID_W-1:0] wr_last
);

  logic [NUM_LOCKS-1:0] busy_q;
  logic [NID_W-1:0]     owner_mem [NUM_LOCKS];
  logic [NID_W-1:0]     last_mem  [NUM_LOCKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else if (wr_en) begin
      busy_q[wr_lock] <= wr_busy;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      owner_mem[wr_lock] <= wr_owner;
      last_mem[wr_lock]  <= wr_last;
    end
  end

  always_comb begin
    rd_busy  = busy_q[rd_lock];
    rd_owner = owner_mem[rd_lock];
    rd_last  = last_mem[rd_lock];
  end

  AST_FREE_CLEARS_LAST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_busy) |-> (wr_last == '0)); // R6

endmodule

// File: rtl/lkq_link_table.sv
module lkq_link_table #(
  parameter int NUM_NODES = 4,
  parameter int NUM_LOCKS = 8,
  localparam int NID_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int LID_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int SLOTS = NUM_NODES * NUM_LOCKS,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LID_W-1:0] rd_lock,
  input  logic [NID_W-1:0] rd_node,
  input  logic [NID_W-1:0] rd_owner,
  output logic             rd_member,
  output logic             rd_succ_valid,
  output logic [NID_W-1:0] rd_succ_id,
  input  logic             mem_we,
  input  logic [NID_W-1:0] mem_node,
  input  logic             mem_set,
  input  logic             lnk_we,
  input  logic [NID_W-1:0] lnk_node,
  input  logic             lnk_valid,
  input  logic [NID_W-1:0] lnk_id,
  input  logic [LID_W-1:0] wr_lock
);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [LID_W-1:0] l,
                                                input logic [NID_W-1:0] n);
    int s;
    s = int'(l) * NUM_NODES + int'(n);
    return SLOT_W'(s);
  endfunction

  logic [SLOTS-1:0] member_q;
  logic [SLOTS-1:0] succ_v_q;
  logic [NID_W-1:0] succ_mem [SLOTS];

  logic [SLOT_W-1:0] rd_req_slot;
  logic [SLOT_W-1:0] rd_own_slot;
  logic [SLOT_W-1:0] mem_slot;
  logic [SLOT_W-1:0] lnk_slot;
  logic [SLOT_W-1:0] tgt_slot;

  always_comb begin
    rd_req_slot = slot_of(rd_lock, rd_node);
    rd_own_slot = slot_of(rd_lock, rd_owner);
    mem_slot    = slot_of(wr_lock, mem_node);
    lnk_slot    = slot_of(wr_lock, lnk_node);
    tgt_slot    = slot_of(wr_lock, lnk_id);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      member_q <= '0;
    end else if (mem_we) begin
      member_q[mem_slot] <= mem_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      succ_v_q <= '0;
    end else if (lnk_we) begin
      succ_v_q[lnk_slot] <= lnk_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (lnk_we) begin
      succ_mem[lnk_slot] <= lnk_id;
    end
  end

  always_comb begin
    rd_member     = member_q[rd_req_slot];
    rd_succ_valid = succ_v_q[rd_own_slot];
    rd_succ_id    = succ_mem[rd_own_slot];
  end

  AST_NO_DOUBLE_LINK: assert property (@(posedge clk) disable iff (rst)
    (lnk_we && lnk_valid) |-> !member_q[tgt_slot]); // R8

  AST_LINK_FROM_MEMBER: assert property (@(posedge clk) disable iff (rst)
    (lnk_we && lnk_valid) |-> member_q[lnk_slot]); // R3

endmodule

// File: rtl/lkq_ctrl.sv
module lkq_ctrl
  import lkq_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int NUM_LOCKS = 8,
  localparam int NID_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic             req_valid,
  input  logic             req_op,
  input  logic [NID_W-1:0] req_node,
  input  logic             cur_busy,
  input  logic [NID_W-1:0] cur_owner,
  input  logic [NID_W-1:0] cur_last,
  input  logic             cur_member,
  input  logic             cur_succ_valid,
  input  logic [NID_W-1:0] cur_succ_id,
  output logic             dir_we,
  output logic             dir_busy,
  output logic [NID_W-1:0] dir_owner,
  output logic [NID_W-1:0] dir_last,
  output logic             mem_we,
  output logic [NID_W-1:0] mem_node,
  output logic             mem_set,
  output logic             lnk_we,
  output logic [NID_W-1:0] lnk_node,
  output logic             lnk_valid,
  output logic [NID_W-1:0] lnk_id,
  output logic             nx_gnt,
  output logic [NID_W-1:0] nx_gnt_node,
  output logic             nx_err,
  output logic             nx_err_kind
);

  logic is_take;
  logic is_give;
  logic owner_match;

  always_comb begin
    is_take     = req_valid && (lk_op_e'(req_op) == OP_TAKE);
    is_give     = req_valid && (lk_op_e'(req_op) == OP_GIVE);
    owner_match = cur_busy && (cur_owner == req_node);

    dir_we      = 1'b0;
    dir_busy    = cur_busy;
    dir_owner   = cur_owner;
    dir_last    = cur_last;
    mem_we      = 1'b0;
    mem_node    = req_node;
    mem_set     = 1'b0;
    lnk_we      = 1'b0;
    lnk_node    = cur_last;
    lnk_valid   = 1'b0;
    lnk_id      = req_node;
    nx_gnt      = 1'b0;
    nx_gnt_node = req_node;
    nx_err      = 1'b0;
    nx_err_kind = ERR_DUP_TAKE;

    if (is_take) begin
      if (cur_member) begin
        nx_err      = 1'b1;
        nx_err_kind = ERR_DUP_TAKE;
      end else if (!cur_busy) begin
        dir_we      = 1'b1;
        dir_busy    = 1'b1;
        dir_owner   = req_node;
        dir_last    = req_node;
        mem_we      = 1'b1;
        mem_set     = 1'b1;
        nx_gnt      = 1'b1;
        nx_gnt_node = req_node;
      end else begin
        dir_we    = 1'b1;
        dir_last  = req_node;
        mem_we    = 1'b1;
        mem_set   = 1'b1;
        lnk_we    = 1'b1;
        lnk_node  = cur_last;
        lnk_valid = 1'b1;
        lnk_id    = req_node;
      end
    end else if (is_give) begin
      if (!owner_match) begin
        nx_err      = 1'b1;
        nx_err_kind = ERR_NOT_OWNER;
      end else if (cur_succ_valid) begin
        dir_we      = 1'b1;
        dir_owner   = cur_succ_id;
        mem_we      = 1'b1;
        mem_set     = 1'b0;
        lnk_we      = 1'b1;
        lnk_node    = req_node;
        lnk_valid   = 1'b0;
        nx_gnt      = 1'b1;
        nx_gnt_node = cur_succ_id;
      end else begin
        dir_we    = 1'b1;
        dir_busy  = 1'b0;
        dir_owner = '0;
        dir_last  = '0;
        mem_we    = 1'b1;
        mem_set   = 1'b0;
      end
    end
  end

  always_comb begin
    AST_SINGLE_OUTCOME: assert (!(nx_gnt && nx_err)); // R10
  end

endmodule

// File: rtl/lkq_lock_mgr.sv
module lkq_lock_mgr
  import lkq_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int NUM_LOCKS = 8,
  localparam int NID_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int LID_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_op,
  input  logic [NID_W-1:0] req_node,
  input  logic [LID_W-1:0] req_lock,
  output logic             gnt_valid,
  output logic [NID_W-1:0] gnt_node,
  output logic [LID_W-1:0] gnt_lock,
  output logic             err_valid,
  output logic             err_kind
);

  logic             cur_busy;
  logic [NID_W-1:0] cur_owner;
  logic [NID_W-1:0] cur_last;
  logic             cur_member;
  logic             cur_succ_valid;
  logic [NID_W-1:0] cur_succ_id;

  logic             dir_we;
  logic             dir_busy;
  logic [NID_W-1:0] dir_owner;
  logic [NID_W-1:0] dir_last;
  logic             mem_we;
  logic [NID_W-1:0] mem_node;
  logic             mem_set;
  logic             lnk_we;
  logic [NID_W-1:0] lnk_node;
  logic             lnk_valid;
  logic [NID_W-1:0] lnk_id;
  logic             nx_gnt;
  logic [NID_W-1:0] nx_gnt_node;
  logic             nx_err;
  logic             nx_err_kind;

  lkq_dir_table #(.NUM_NODES(NUM_NODES), .NUM_LOCKS(NUM_LOCKS)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .rd_lock  (req_lock),
    .rd_busy  (cur_busy),
    .rd_owner (cur_owner),
    .rd_last  (cur_last),
    .wr_en    (dir_we),
    .wr_lock  (req_lock),
    .wr_busy  (dir_busy),
    .wr_owner (dir_owner),
    .wr_last  (dir_last)
  );

  lkq_link_table #(.NUM_NODES(NUM_NODES), .NUM_LOCKS(NUM_LOCKS)) u_lnk (
    .clk           (clk),
    .rst           (rst),
    .rd_lock       (req_lock),
    .rd_node       (req_node),
    .rd_owner      (cur_owner),
    .rd_member     (cur_member),
    .rd_succ_valid (cur_succ_valid),
    .rd_succ_id    (cur_succ_id),
    .mem_we        (mem_we),
    .mem_node      (mem_node),
    .mem_set       (mem_set),
    .lnk_we        (lnk_we),
    .lnk_node      (lnk_node),
    .lnk_valid     (lnk_valid),
    .lnk_id        (lnk_id),
    .wr_lock       (req_lock)
  );

  lkq_ctrl #(.NUM_NODES(NUM_NODES), .NUM_LOCKS(NUM_LOCKS)) u_ctl (
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_node       (req_node),
    .cur_busy       (cur_busy),
    .cur_owner      (cur_owner),
    .cur_last       (cur_last),
    .cur_member     (cur_member),
    .cur_succ_valid (cur_succ_valid),
    .cur_succ_id    (cur_succ_id),
    .dir_we         (dir_we),
    .dir_busy       (dir_busy),
    .dir_owner      (dir_owner),
    .dir_last       (dir_last),
    .mem_we         (mem_we),
    .mem_node       (mem_node),
    .mem_set        (mem_set),
    .lnk_we         (lnk_we),
    .lnk_node       (lnk_node),
    .lnk_valid      (lnk_valid),
    .lnk_id         (lnk_id),
    .nx_gnt         (nx_gnt),
    .nx_gnt_node    (nx_gnt_node),
    .nx_err         (nx_err),
    .nx_err_kind    (nx_err_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_node  <= '0;
      gnt_lock  <= '0;
      err_valid <= 1'b0;
      err_kind  <= 1'b0;
    end else begin
      gnt_valid <= nx_gnt;
      gnt_node  <= nx_gnt_node;
      gnt_lock  <= req_lock;
      err_valid <= nx_err;
      err_kind  <= nx_err_kind;
    end
  end

  AST_FREE_TAKE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op && !cur_busy && !cur_member) |=>
      (gnt_valid && gnt_node == $past(req_node) && gnt_lock == $past(req_lock))); // R2

  AST_QUEUED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op && cur_busy && !cur_member) |=>
      (!gnt_valid && !err_valid)); // R3

  AST_FOREIGN_GIVE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op && (!cur_busy || cur_owner != req_node)) |=>
      (err_valid && err_kind && !gnt_valid)); // R7

  AST_DUP_TAKE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op && cur_member) |=>
      (err_valid && !err_kind && !gnt_valid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!gnt_valid && !err_valid)); // R10

endmodule

// File: tb/sim_lkq_lock_mgr.sv
module sim_lkq_lock_mgr;

  localparam int NN = 4;
  localparam int NL = 8;
  localparam int NW = 2;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_op = 1'b0;
  logic [NW-1:0] req_node = '0;
  logic [LW-1:0] req_lock = '0;
  logic          gnt_valid;
  logic [NW-1:0] gnt_node;
  logic [LW-1:0] gnt_lock;
  logic          err_valid;
  logic          err_kind;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int q   [NL][NN];
  int cnt [NL];

  always #5 clk = ~clk;

  lkq_lock_mgr #(.NUM_NODES(NN), .NUM_LOCKS(NL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_node(req_node), .req_lock(req_lock), .gnt_valid(gnt_valid),
    .gnt_node(gnt_node), .gnt_lock(gnt_lock), .err_valid(err_valid),
    .err_kind(err_kind)
  );

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      summary_and_end();
    end
  end

  task automatic check_out(input string tag, input logic eg, input int en,
                           input int el, input logic ee, input logic ek);
    logic bad;
    checks = checks + 1;
    bad = (gnt_valid !== eg) || (err_valid !== ee);
    if (eg && (int'(gnt_node) != en || int'(gnt_lock) != el)) bad = 1'b1;
    if (ee && err_kind !== ek) bad = 1'b1;
    if (bad) begin
      errors = errors + 1;
      $display("FAIL %s: actual g=%0b n=%0d l=%0d e=%0b k=%0b expected g=%0b n=%0d l=%0d e=%0b k=%0b",
               tag, gnt_valid, gnt_node, gnt_lock, err_valid, err_kind,
               eg, en, el, ee, ek);
    end
  endtask

  function automatic bit in_queue(int l, int n);
    for (int i = 0; i < cnt[l]; i++) if (q[l][i] == n) return 1;
    return 0;
  endfunction

  task automatic do_op(input int n, input int l, input int op, input string ovr = "");
    logic eg, ee, ek;
    int en;
    string tag;
    eg = 0; ee = 0; ek = 0; en = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op[0];
    req_node  = NW'(n);
    req_lock  = LW'(l);
    if (op == 0) begin
      if (in_queue(l, n)) begin
        ee = 1; ek = 0; tag = "R8";
      end else if (cnt[l] == 0) begin
        q[l][0] = n; cnt[l] = 1; eg = 1; en = n; tag = "R2";
      end else begin
        q[l][cnt[l]] = n; cnt[l] = cnt[l] + 1; tag = "R3";
      end
    end else begin
      if (cnt[l] == 0 || q[l][0] != n) begin
        ee = 1; ek = 1; tag = "R7";
      end else if (cnt[l] > 1) begin
        for (int i = 0; i < cnt[l] - 1; i++) q[l][i] = q[l][i+1];
        cnt[l] = cnt[l] - 1;
        eg = 1; en = q[l][0]; tag = "R4/R5";
      end else begin
        cnt[l] = 0; tag = "R6";
      end
    end
    if (ovr != "") tag = ovr;
    @(posedge clk);
    #1;
    check_out(tag, eg, en, l, ee, ek);
    req_valid = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check_out("R10", 1'b0, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    int unsigned seed;
    for (int l = 0; l < NL; l++) cnt[l] = 0;
    repeat (3) @(posedge clk);
    #1;
    check_out("R1", 1'b0, 0, 0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    idle_check();

    // R1: every lock is free after reset
    for (int l = 0; l < NL; l++) do_op(l % NN, l, 0, "R1");
    for (int l = 0; l < NL; l++) do_op(l % NN, l, 1, "R6");

    // R2, R3, R8, R7, R4, R5, R6 on lock 0
    do_op(1, 0, 0);
    do_op(2, 0, 0);
    do_op(3, 0, 0);
    do_op(0, 0, 0);
    do_op(2, 0, 0);
    do_op(1, 0, 0);
    do_op(3, 0, 1);
    idle_check();
    do_op(1, 0, 1);
    do_op(2, 0, 1);
    // R9: lock 5 is unaffected by lock 0 traffic
    do_op(0, 5, 0, "R9");
    do_op(3, 5, 0, "R9");
    do_op(3, 0, 1);
    do_op(0, 0, 1);
    do_op(3, 0, 0);
    do_op(0, 5, 1, "R9");
    do_op(3, 5, 1, "R9");
    do_op(3, 0, 1);
    do_op(2, 2, 1);

    // Near-exhaustive pseudo-random sweep
    seed = 32'h1234_5677;
    for (int k = 0; k < 6000; k++) begin
      int n, l, op;
      seed = seed * 1103515245 + 12345;
      l  = int'((seed >> 8) % NL);
      n  = int'((seed >> 12) % NN);
      op = int'((seed >> 16) & 1);
      if (op == 1 && ((seed >> 20) & 3) != 0 && cnt[l] > 0) n = q[l][0];
      if (((seed >> 24) & 15) == 0) idle_check();
      else do_op(n, l, op);
    end

    summary_and_end();
  end

endmodule